// File: doc/BRIEF.md
# Bus-off recovery controller

This block decides when a CAN node that has gone bus-off may take part in bus traffic again. After a bus-off entry pulse it raises a status flag. It then watches the sampled bus bits and counts complete runs of 11 consecutive recessive bits. When the required number of runs has been seen, it emits a one-cycle rejoin pulse that the error counter logic uses to reset itself, and it drops the status flag.

A software hold bit can stop the node from recovering on its own. The block captures the hold bit at bus-off entry, and that captured copy governs the whole episode. Clearing the hold during counting makes the episode behave like a normal one. Clearing it after the full count has been reached makes the node wait for one more recessive run before it rejoins. Setting the hold after entry has no effect until the next episode.

The run length and the required number of runs are parameters. Error counter arithmetic, frame handling and interrupts are handled elsewhere.

Top module: `busoff_recovery`

## Requirements
- R1: While rst_ni is low, and after reset, busoff_o and rejoin_o are 0. Reset acts asynchronously and also ends an episode that is in progress.
- R2: A busoff_enter_i pulse sets busoff_o at the next clock edge.
- R3: Without hold, the 11th recessive bit of the 128th run sets rejoin_o high and busoff_o low at the edge that samples that bit. rejoin_o stays high for exactly one cycle.
- R4: A valid dominant bit (bit_value_i = 0) discards the partial recessive run. Only 11 uninterrupted recessive bits count as a run.
- R5: Cycles with bit_valid_i = 0 neither extend nor break a run, whatever the value on bit_value_i. A recessive bit is bit_value_i = 1.
- R6: If recov_hold_i = 1 at entry and stays 1, busoff_o stays high after 128 runs and after any number of further runs.
- R7: If a hold that was captured at entry is cleared before the 128th run completes, recovery happens at the 128th run, as if no hold had been set.
- R8: If the hold is cleared after 128 runs, the node rejoins after one further run of 11 recessive bits that starts after the release.
- R9: Setting recov_hold_i after entry, when it was 0 at entry, does not delay the current recovery.
- R10: A busoff_enter_i pulse during bus-off restarts the count from zero and captures the hold bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busoff_enter_i | input | 1 | One-cycle pulse: node enters bus-off |
| bit_valid_i | input | 1 | Strobe marking a sampled bus bit |
| bit_value_i | input | 1 | Sampled bit, 1 = recessive, 0 = dominant |
| recov_hold_i | input | 1 | 1 = suppress automatic recovery |
| busoff_o | output | 1 | Node is in bus-off |
| rejoin_o | output | 1 | One-cycle pulse on leaving bus-off; resets error counters |

## Verification
busoff_o rises one clock edge after the entry pulse is sampled. rejoin_o rises, and busoff_o falls, at the same edge that samples the bit completing the final run. No further register delay is added.

The bench changes inputs on falling edges. Each bit-sending task returns at the falling edge after the last bit has been sampled, so results are checked there. The pulse width is checked one falling edge later.

Every recovery case is checked twice: once on the bit just before completion, which must leave the node in bus-off, and once on the completing bit, which must produce the rejoin pulse.

// File: rtl/busoff_pkg.sv
package busoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_HELD   = 2'd2,
    ST_RESYNC = 2'd3
  } rec_state_e;
endpackage

// File: rtl/busoff_run_counter.sv
module busoff_run_counter #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic clear_i,
  input  logic bit_valid_i,
  input  logic bit_value_i,
  output logic run_done_o
);
  localparam int unsigned CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last    = (cnt_q == LAST);
  assign run_done_o = enable_i && !clear_i && bit_valid_i && bit_value_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || !enable_i) begin
      cnt_q <= '0;
    end else if (bit_valid_i) begin
      // dominant bit or completed run restarts the count
      if (!bit_value_i || at_last) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/busoff_seq_counter.sv
module busoff_seq_counter #(
  parameter int unsigned SEQ_TARGET = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic incr_i,
  output logic final_o
);
  localparam int unsigned SEQ_W = $clog2(SEQ_TARGET + 1);
  localparam logic [SEQ_W-1:0] LAST = SEQ_W'(SEQ_TARGET - 1);
  localparam logic [SEQ_W-1:0] SAT  = SEQ_W'(SEQ_TARGET);

  logic [SEQ_W-1:0] cnt_q;

  assign final_o = incr_i && !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (incr_i && (cnt_q != SAT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/busoff_recovery_fsm.sv
module busoff_recovery_fsm
  import busoff_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busoff_enter_i,
  input  logic       recov_hold_i,
  input  logic       run_done_i,
  input  logic       seq_final_i,
  output rec_state_e state_o,
  output logic       clr_run_o,
  output logic       clr_seq_o,
  output logic       rejoin_o
);
  rec_state_e state_q, state_d;
  logic       hold_q, hold_d;
  logic       rejoin_q, rejoin_d;

  always_comb begin
    state_d   = state_q;
    hold_d    = hold_q;
    rejoin_d  = 1'b0;
    clr_run_o = 1'b0;
    clr_seq_o = 1'b0;
    if (busoff_enter_i) begin
      // entry or re-entry: capture hold, restart from zero
      state_d   = ST_COUNT;
      hold_d    = recov_hold_i;
      clr_run_o = 1'b1;
      clr_seq_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          clr_run_o = 1'b1;
          clr_seq_o = 1'b1;
        end
        ST_COUNT: begin
          if (!recov_hold_i) hold_d = 1'b0;
          if (seq_final_i) begin
            if (hold_q && recov_hold_i) begin
              state_d = ST_HELD;
            end else begin
              state_d  = ST_IDLE;
              rejoin_d = 1'b1;
            end
          end
        end
        ST_HELD: begin
          if (!recov_hold_i) begin
            state_d   = ST_RESYNC;
            hold_d    = 1'b0;
            clr_run_o = 1'b1;
          end
        end
        ST_RESYNC: begin
          if (run_done_i) begin
            state_d  = ST_IDLE;
            rejoin_d = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      hold_q   <= 1'b0;
      rejoin_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      hold_q   <= hold_d;
      rejoin_q <= rejoin_d;
    end
  end

  assign state_o  = state_q;
  assign rejoin_o = rejoin_q;
endmodule

// File: rtl/busoff_recovery.sv
module busoff_recovery
  import busoff_pkg::*;
#(
  parameter int unsigned RUN_LEN    = 11,
  parameter int unsigned SEQ_TARGET = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busoff_enter_i,
  input  logic bit_valid_i,
  input  logic bit_value_i,
  input  logic recov_hold_i,
  output logic busoff_o,
  output logic rejoin_o
);
  rec_state_e state;
  logic       clr_run, clr_seq;
  logic       run_done, seq_final;
  logic       run_en, seq_incr;

  assign run_en   = (state != ST_IDLE);
  assign seq_incr = run_done && (state == ST_COUNT);

  busoff_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (run_en),
    .clear_i     (clr_run),
    .bit_valid_i (bit_valid_i),
    .bit_value_i (bit_value_i),
    .run_done_o  (run_done)
  );

  busoff_seq_counter #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clr_seq),
    .incr_i  (seq_incr),
    .final_o (seq_final)
  );

  busoff_recovery_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .busoff_enter_i (busoff_enter_i),
    .recov_hold_i   (recov_hold_i),
    .run_done_i     (run_done),
    .seq_final_i    (seq_final),
    .state_o        (state),
    .clr_run_o      (clr_run),
    .clr_seq_o      (clr_seq),
    .rejoin_o       (rejoin_o)
  );

  assign busoff_o = (state != ST_IDLE);
endmodule

// File: rtl/busoff_recovery_chk.sv
module busoff_recovery_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busoff_enter_i,
  input logic bit_valid_i,
  input logic bit_value_i,
  input logic recov_hold_i,
  input logic busoff_o,
  input logic rejoin_o
);
  // hold as captured per episode, observed from ports only
  logic ep_hold_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ep_hold_q <= 1'b0;
    else if (busoff_enter_i) ep_hold_q <= recov_hold_i;
    else if (!recov_hold_i)  ep_hold_q <= 1'b0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!busoff_o && !rejoin_o);
    end
  end

  assert_entry_sets_busoff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_enter_i |=> busoff_o);

  assert_rejoin_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejoin_o |=> !rejoin_o);

  assert_rejoin_leaves_busoff_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejoin_o |-> (!busoff_o && $past(busoff_o)));

  assert_dominant_no_rejoin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && !bit_value_i) |=> !rejoin_o);

  assert_rejoin_after_recessive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejoin_o |-> $past(bit_valid_i && bit_value_i && !busoff_enter_i));

  assert_held_no_rejoin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busoff_o && ep_hold_q && recov_hold_i) |=> !rejoin_o);
endmodule

bind busoff_recovery busoff_recovery_chk u_chk (.*);

// File: tb/sim_busoff_recovery.sv
module sim_busoff_recovery;
  localparam int RUN = 11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic busoff_enter_i = 1'b0;
  logic bit_valid_i = 1'b0;
  logic bit_value_i = 1'b0;
  logic recov_hold_i = 1'b0;
  logic busoff_o, rejoin_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  busoff_recovery u0 (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .busoff_enter_i (busoff_enter_i),
    .bit_valid_i    (bit_valid_i),
    .bit_value_i    (bit_value_i),
    .recov_hold_i   (recov_hold_i),
    .busoff_o       (busoff_o),
    .rejoin_o       (rejoin_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic send_bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      bit_valid_i = 1'b1;
      bit_value_i = v;
    end
    @(negedge clk_i);
    bit_valid_i = 1'b0;
  endtask

  task automatic enter_busoff();
    @(negedge clk_i);
    busoff_enter_i = 1'b1;
    @(negedge clk_i);
    busoff_enter_i = 1'b0;
  endtask

  task automatic expect_pending(input string req);
    check({req, " busoff held"}, busoff_o, 1);
    check({req, " no rejoin"}, rejoin_o, 0);
  endtask

  task automatic expect_rejoin(input string req);
    check({req, " rejoin pulse"}, rejoin_o, 1);
    check({req, " busoff cleared"}, busoff_o, 0);
    @(negedge clk_i);
    check({req, " pulse one cycle"}, rejoin_o, 0);
  endtask

  task automatic test_reset_r1();
    check("R1 reset busoff", busoff_o, 0);
    check("R1 reset rejoin", rejoin_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", busoff_o, 0);
    enter_busoff();
    @(negedge clk_i) rst_ni = 1'b0;
    #2;
    check("R1 async reset ends episode", busoff_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic test_auto_r3();
    enter_busoff();
    check("R2 entry sets busoff", busoff_o, 1);
    send_bits(127 * RUN + 10, 1'b1);
    expect_pending("R3");
    send_bits(1, 1'b1);
    expect_rejoin("R3");
  endtask

  task automatic test_dominant_r4();
    enter_busoff();
    send_bits(10, 1'b1);
    send_bits(1, 1'b0);
    send_bits(127 * RUN + 10, 1'b1);
    expect_pending("R4");
    send_bits(1, 1'b1);
    expect_rejoin("R4");
  endtask

  task automatic test_invalid_r5();
    enter_busoff();
    send_bits(5, 1'b1);
    bit_value_i = 1'b0;
    repeat (20) @(negedge clk_i);
    send_bits(6, 1'b1);
    send_bits(126 * RUN + 10, 1'b1);
    bit_value_i = 1'b1;
    repeat (20) @(negedge clk_i);
    expect_pending("R5");
    send_bits(1, 1'b1);
    expect_rejoin("R5");
  endtask

  task automatic test_held_r6_r8();
    recov_hold_i = 1'b1;
    enter_busoff();
    send_bits(128 * RUN, 1'b1);
    expect_pending("R6");
    send_bits(30 * RUN, 1'b1);
    expect_pending("R6 extra runs");
    @(negedge clk_i) recov_hold_i = 1'b0;
    repeat (2) @(negedge clk_i);
    expect_pending("R8 release");
    send_bits(10, 1'b1);
    expect_pending("R8");
    send_bits(1, 1'b1);
    expect_rejoin("R8");
  endtask

  task automatic test_early_clear_r7();
    recov_hold_i = 1'b1;
    enter_busoff();
    send_bits(100 * RUN, 1'b1);
    @(negedge clk_i) recov_hold_i = 1'b0;
    send_bits(27 * RUN + 10, 1'b1);
    expect_pending("R7");
    send_bits(1, 1'b1);
    expect_rejoin("R7");
  endtask

  task automatic test_late_set_r9();
    recov_hold_i = 1'b0;
    enter_busoff();
    @(negedge clk_i) recov_hold_i = 1'b1;
    send_bits(127 * RUN + 10, 1'b1);
    expect_pending("R9");
    send_bits(1, 1'b1);
    expect_rejoin("R9");
    recov_hold_i = 1'b0;
  endtask

  task automatic test_reentry_r10();
    enter_busoff();
    send_bits(100 * RUN, 1'b1);
    enter_busoff();
    check("R10 still busoff", busoff_o, 1);
    send_bits(127 * RUN + 10, 1'b1);
    expect_pending("R10");
    send_bits(1, 1'b1);
    expect_rejoin("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset_r1();
    test_auto_r3();
    test_dominant_r4();
    test_invalid_r5();
    test_held_r6_r8();
    test_early_clear_r7();
    test_late_set_r9();
    test_reentry_r10();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule